// File: doc/BRIEF.md
# Embedded-Clock Frame Lock and Deframer

This block sits behind a bit-level receiver that already delivers one recovered line bit per clock. The serial stream is cut into 18-bit frames: a 16-bit payload followed by a pair of framing bits, a 0 and then a 1. The block does not know where a frame starts. It finds the boundary by watching every one of the 18 bit positions in the frame for a 0 bit followed by a 1 bit. It settles on the single position that shows this pair repeatedly and in isolation. It then delivers each payload as a parallel word with a one-cycle strobe, and it raises an active-low lock flag together with an output-enable.

Ordinary traffic is enough to acquire lock; no training pattern is needed. The block refuses to lock while a second position also keeps producing the 0-to-1 pair. Once locked, the payload content has no effect on lock. Lock is dropped only when the framing pair is wrong in two frames in a row, and the search then starts over.

A loopback select bypasses the line path entirely and drives the local transmit word and its strobe straight onto the receive outputs.

Top module: `eclk_deframer`

## Requirements
- R1: Each frame on `line_bit` carries the payload first, most significant bit first, then a 0 framing bit, then a 1 framing bit. `rx_word[15]` is the first payload bit received.
- R2: With the payload held at 16'hFF00, `lock_n` falls within 6 frames (108 bit clocks) of the first frame's first bit.
- R3: While unlocked, lock is declared only if two conditions hold: one position has shown the 0-to-1 pair in 4 consecutive frames, and no other position has shown it in 3 or more consecutive frames. With the payload held at 16'h00FF, which makes a second persistent pair, the block stays unlocked. Once the payload changes so that the second pair stops repeating, lock follows.
- R4: While locked, the payload content never causes loss of lock. This holds for fixed patterns that contain a repeating 0-to-1 pair, for fixed patterns, and for alternating patterns.
- R5: While locked, a single frame with a wrong framing pair keeps lock. The next correct pair clears the error count, so the sequence bad, good, bad keeps lock.
- R6: Two consecutive frames with a wrong framing pair drop lock. After that, `lock_n` is 1, `rx_oe` is 0, and no strobe is issued.
- R7: While locked, `rx_stb` pulses for exactly one cycle per frame. The pulse comes in the cycle after the edge that samples the 1 framing bit, and `rx_word` then holds that frame's payload. No strobe is issued while unlocked.
- R8: After reset, and at any time while unlocked, `lock_n` is 1, `rx_oe` is 0 and `rx_stb` is 0. While locked, `lock_n` is 0 and `rx_oe` is 1.
- R9: With `lb_en` set to 1, the following hold combinationally: `rx_word` equals `tx_word`, `rx_stb` equals `tx_stb`, `rx_oe` is 1 and `lock_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit | input | 1 | Recovered serial line bit |
| lb_en | input | 1 | Local loopback select |
| tx_word | input | 16 | Local transmit word used in loopback |
| tx_stb | input | 1 | Local transmit strobe used in loopback |
| rx_word | output | 16 | Received payload word |
| rx_stb | output | 1 | One-cycle word strobe |
| rx_oe | output | 1 | Output enable; low models tri-stated data |
| lock_n | output | 1 | Active-low lock indication |

## Verification
The hardest state to reach from the ports is an unlocked receiver facing two positions that both repeat the 0-to-1 pair. Reaching it requires first forcing loss of lock, and then presenting a payload that itself contains a fixed 0-to-1 step. The stimulus gets there by sending two frames with swapped framing bits, and then a run of frames holding 16'h00FF. It then switches to a payload that alternates with its complement. This alternation cancels every in-payload pair from one frame to the next, so acquisition can be timed against the bound.

// File: rtl/eclk_pkg.sv
package eclk_pkg;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ACQ_FRAMES = 4;
    localparam int unsigned ERR_LIMIT = 2;
endpackage

// File: rtl/eclk_pos_track.sv
// Per-position run counters: counts consecutive frames in which the
// bit at a position completes a 0-to-1 pair.
module eclk_pos_track #(
    parameter int unsigned NPOS       = 18,
    parameter int unsigned ACQ_FRAMES = 4,
    localparam int unsigned PW = $clog2(NPOS),
    localparam int unsigned CW = $clog2(ACQ_FRAMES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [PW-1:0]   ph,
    input  logic            hit,
    output logic [NPOS-1:0] sat,
    output logic [NPOS-1:0] near
);
    typedef struct packed {
        logic [NPOS-1:0][CW-1:0] cnt;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else begin
            for (int k = 0; k < NPOS; k++) begin
                if (ph == PW'(k)) begin
                    if (!hit)
                        s_d.cnt[k] = '0;
                    else if (s_q.cnt[k] != CW'(ACQ_FRAMES))
                        s_d.cnt[k] = s_q.cnt[k] + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar k = 0; k < NPOS; k++) begin : g_pos
        assign sat[k]  = (s_q.cnt[k] == CW'(ACQ_FRAMES));
        assign near[k] = (s_q.cnt[k] >= CW'(ACQ_FRAMES - 1));

        // R3: a position that misses its pair loses its run
        p_miss_clears_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && ph == PW'(k) && !hit) |=> (s_q.cnt[k] == '0));
    end
endmodule

// File: rtl/eclk_lock_ctrl.sv
// Lock state, chosen alignment, framing-error count and word capture.
module eclk_lock_ctrl #(
    parameter int unsigned NPOS      = 18,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ERR_LIMIT = 2,
    localparam int unsigned PW = $clog2(NPOS),
    localparam int unsigned EW = $clog2(ERR_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     ph,
    input  logic              hit,
    input  logic [DATA_W-1:0] win_word,
    input  logic [NPOS-1:0]   sat,
    input  logic [NPOS-1:0]   near,
    output logic              clr,
    output logic              locked,
    output logic              stb,
    output logic [DATA_W-1:0] word
);
    typedef struct packed {
        logic              locked;
        logic [PW-1:0]     pos;
        logic [EW-1:0]     err;
        logic              stb;
        logic [DATA_W-1:0] word;
    } ctl_t;

    ctl_t          s_d, s_q;
    logic          go_lock;
    logic          unique_ok;
    logic [PW-1:0] sel;

    always_comb begin
        s_d       = s_q;
        s_d.stb   = 1'b0;
        go_lock   = 1'b0;
        sel       = '0;
        for (int k = 0; k < NPOS; k++)
            if (sat[k]) sel = PW'(k);
        unique_ok = ($countones(sat) == 1) && ($countones(near) == 1);

        if (!s_q.locked) begin
            if (unique_ok) begin
                go_lock    = 1'b1;
                s_d.locked = 1'b1;
                s_d.pos    = sel;
                s_d.err    = '0;
            end
        end else if (ph == s_q.pos) begin
            if (hit) begin
                s_d.err  = '0;
                s_d.stb  = 1'b1;
                s_d.word = win_word;
            end else if (s_q.err == EW'(ERR_LIMIT - 1)) begin
                s_d.locked = 1'b0;
                s_d.err    = '0;
            end else begin
                s_d.err  = s_q.err + EW'(1);
                s_d.stb  = 1'b1;
                s_d.word = win_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clr    = s_q.locked | go_lock;
    assign locked = s_q.locked;
    assign stb    = s_q.stb;
    assign word   = s_q.word;

    // R3: a second near-persistent candidate blocks lock
    p_ambiguity_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.locked && $countones(near) > 1) |=> !s_q.locked);
    // R5: first bad pair keeps lock
    p_one_miss_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && ph == s_q.pos && !hit && s_q.err == '0) |=> s_q.locked);
    // R5: a good pair clears the error count
    p_good_pair_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && ph == s_q.pos && hit) |=> (s_q.err == '0));
    // R6: reaching the error limit drops lock
    p_limit_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && ph == s_q.pos && !hit && s_q.err == EW'(ERR_LIMIT - 1)) |=> !s_q.locked);
    // R7: strobe only while locked
    p_stb_in_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stb |-> s_q.locked);
endmodule

// File: rtl/eclk_deframer.sv
module eclk_deframer #(
    parameter int unsigned DATA_W     = eclk_pkg::DATA_W,
    parameter int unsigned ACQ_FRAMES = eclk_pkg::ACQ_FRAMES,
    parameter int unsigned ERR_LIMIT  = eclk_pkg::ERR_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_bit,
    input  logic              lb_en,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_stb,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_stb,
    output logic              rx_oe,
    output logic              lock_n
);
    localparam int unsigned NPOS = DATA_W + 2;
    localparam int unsigned PW   = $clog2(NPOS);

    typedef struct packed {
        logic [PW-1:0]   ph;
        logic [DATA_W:0] sr;
    } fe_t;

    fe_t               s_d, s_q;
    logic              hit;
    logic [NPOS-1:0]   sat, near;
    logic              clr, locked, stb;
    logic [DATA_W-1:0] word;

    always_comb begin
        s_d    = s_q;
        s_d.sr = {s_q.sr[DATA_W-1:0], line_bit};
        s_d.ph = (s_q.ph == PW'(NPOS - 1)) ? '0 : s_q.ph + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit = line_bit & ~s_q.sr[0];

    eclk_pos_track #(.NPOS(NPOS), .ACQ_FRAMES(ACQ_FRAMES)) u_trk (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ph(s_q.ph), .hit(hit),
        .sat(sat), .near(near)
    );

    eclk_lock_ctrl #(.NPOS(NPOS), .DATA_W(DATA_W), .ERR_LIMIT(ERR_LIMIT)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ph(s_q.ph), .hit(hit),
        .win_word(s_q.sr[DATA_W:1]), .sat(sat), .near(near),
        .clr(clr), .locked(locked), .stb(stb), .word(word)
    );

    assign rx_word = lb_en ? tx_word : (locked ? word : '0);
    assign rx_stb  = lb_en ? tx_stb : stb;
    assign rx_oe   = lb_en | locked;
    assign lock_n  = ~(lb_en | locked);

    p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ph < PW'(NPOS));
    // R8: while unlocked on the line path, outputs are disabled
    p_unlocked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lb_en && lock_n) |-> (!rx_oe && !rx_stb));
endmodule

// File: tb/sim_eclk_deframer.sv
`timescale 1ns/1ps
module sim_eclk_deframer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_bit = 1'b0;
    logic        lb_en = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_stb = 1'b0;
    logic [15:0] rx_word;
    logic        rx_stb, rx_oe, lock_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int stb_cnt = 0;
    int lock_fall_cyc = -1;
    bit mon_on = 1'b0;
    bit ever_locked = 1'b0;
    logic prev_lock_n = 1'b1;
    logic [15:0] exp_q[$];

    eclk_deframer u0 (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .lb_en(lb_en),
        .tx_word(tx_word), .tx_stb(tx_stb), .rx_word(rx_word),
        .rx_stb(rx_stb), .rx_oe(rx_oe), .lock_n(lock_n)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver: payload MSB first, then two framing bits; pushes expectation
    task automatic send_frame(input logic [15:0] p, input bit c0 = 1'b0, input bit c1 = 1'b1);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); line_bit = p[i];
        end
        @(negedge clk); line_bit = c0;
        @(negedge clk); line_bit = c1;
        exp_q.push_back(p);
    endtask

    // monitor / scoreboard
    always begin
        @(posedge clk); #5;
        if (mon_on) begin
            if (!lock_n) ever_locked = 1'b1;
            if (prev_lock_n && !lock_n && lock_fall_cyc < 0) lock_fall_cyc = cyc;
            prev_lock_n = lock_n;
            if (rx_stb) begin
                stb_cnt++;
                chk(!lock_n, "R7", "strobe while unlocked", 32'(lock_n), 32'd0);
                if (exp_q.size() == 0)
                    chk(1'b0, "R7", "strobe with empty scoreboard", 32'(rx_word), 32'd0);
                else
                    chk(rx_word == exp_q[$], "R1,R7", "payload word", 32'(rx_word), 32'(exp_q[$]));
                exp_q.delete();
            end
        end
    end

    initial begin
        #(20 * 100000);
        chk(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int s;
        int start;
        repeat (3) @(negedge clk);
        chk(lock_n == 1'b1, "R8", "reset lock_n", 32'(lock_n), 32'd1);
        chk(rx_oe == 1'b0, "R8", "reset oe", 32'(rx_oe), 32'd0);
        chk(rx_stb == 1'b0, "R8", "reset stb", 32'(rx_stb), 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: sync payload acquisition within bound
        start = cyc; lock_fall_cyc = -1;
        repeat (6) send_frame(16'hFF00);
        chk(lock_fall_cyc >= 0 && (lock_fall_cyc - start) <= 108, "R2",
            "sync lock latency", 32'(lock_fall_cyc - start), 32'd108);
        chk(rx_oe == 1'b1, "R8", "oe when locked", 32'(rx_oe), 32'd1);

        // R1, R7: alternating traffic, one strobe per frame
        s = stb_cnt;
        for (int i = 0; i < 8; i++) send_frame(i[0] ? ~16'h1234 : 16'h1234);
        chk(stb_cnt - s == 8, "R7", "strobes per frame", 32'(stb_cnt - s), 32'd8);

        // R4: payloads with repeating pairs and fixed data keep lock
        repeat (6) send_frame(16'h00FF);
        chk(lock_n == 1'b0, "R4", "lock with rmt payload", 32'(lock_n), 32'd0);
        repeat (3) send_frame(16'h5A5A);
        repeat (3) send_frame(16'hFF00);
        chk(lock_n == 1'b0, "R4", "lock with fixed payload", 32'(lock_n), 32'd0);

        // R5: isolated bad pairs
        s = stb_cnt;
        send_frame(16'hC3A1, 1'b1, 1'b0);
        send_frame(~16'hC3A1);
        send_frame(16'hC3A1, 1'b1, 1'b0);
        send_frame(~16'hC3A1);
        send_frame(16'hC3A1);
        chk(lock_n == 1'b0, "R5", "lock after isolated errors", 32'(lock_n), 32'd0);
        chk(stb_cnt - s == 5, "R5", "strobes through isolated errors", 32'(stb_cnt - s), 32'd5);

        // R6: two consecutive bad pairs
        send_frame(16'h0F1E, 1'b1, 1'b0);
        send_frame(~16'h0F1E, 1'b1, 1'b0);
        s = stb_cnt;
        send_frame(16'h00FF);
        chk(lock_n == 1'b1, "R6", "lock_n after two errors", 32'(lock_n), 32'd1);
        chk(rx_oe == 1'b0, "R6", "oe after two errors", 32'(rx_oe), 32'd0);

        // R3: persistent second candidate holds off lock
        ever_locked = 1'b0;
        repeat (8) send_frame(16'h00FF);
        chk(!ever_locked, "R3", "no lock with two candidates", 32'(ever_locked), 32'd0);
        chk(stb_cnt - s <= 1, "R6", "no strobes while unlocked", 32'(stb_cnt - s), 32'd1);
        start = cyc; lock_fall_cyc = -1; prev_lock_n = 1'b1;
        for (int i = 0; i < 7; i++) send_frame(i[0] ? ~16'h1234 : 16'h1234);
        chk(lock_fall_cyc >= 0 && (lock_fall_cyc - start) <= 126, "R3",
            "relock after candidate clears", 32'(lock_fall_cyc - start), 32'd126);
        for (int i = 0; i < 4; i++) send_frame(i[0] ? ~16'h8E31 : 16'h8E31);

        // R9: loopback
        mon_on = 1'b0;
        @(negedge clk);
        lb_en = 1'b1; tx_word = 16'hBEEF; tx_stb = 1'b1;
        #1;
        chk(rx_word == 16'hBEEF, "R9", "loopback word", 32'(rx_word), 32'hBEEF);
        chk(rx_stb == 1'b1, "R9", "loopback strobe", 32'(rx_stb), 32'd1);
        chk(rx_oe == 1'b1, "R9", "loopback oe", 32'(rx_oe), 32'd1);
        chk(lock_n == 1'b0, "R9", "loopback lock_n", 32'(lock_n), 32'd0);
        tx_stb = 1'b0; tx_word = 16'h0F0F;
        #1;
        chk(rx_stb == 1'b0, "R9", "loopback strobe low", 32'(rx_stb), 32'd0);
        chk(rx_word == 16'h0F0F, "R9", "loopback word 2", 32'(rx_word), 32'h0F0F);
        @(negedge clk);
        lb_en = 1'b0;
        finish_run();
    end
endmodule